// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status and Mask Unit

This block collects the event pulses of an SD/MMC host controller into sticky status bits, lets software block individual sources through a mask register, and drives one registered interrupt request line. Eleven event sources are latched: command response done, command timeout, data phase done, CRC error, data timeout, receive data ready, transmit data request, receive overflow, transmit underrun, card inserted and card removed. Two level inputs, write-protect and command-busy, appear live in the same status word. They never raise an interrupt.

Software clears events by writing the complement of the bits it wants to drop. A 0 in the written word clears the bit, and a 1 keeps it. A mask bit at 1 blocks its source from the interrupt line. The latched bit stays readable while it is masked. A second, 16-bit status and mask pair serves the card I/O interrupt, together with an enable register. Card I/O events are neither latched nor signalled while that enable is off. Both the SD and the card I/O pending terms drive the same request output.

Register map (word address on `bus_addr`): 0 status, 1 mask, 2 card I/O status, 3 card I/O mask, 4 card I/O enable. All other addresses read as zero. Reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_we` is high.

Top module: `sdmmc_irq_agg`

## Requirements
- R1: After reset the status reads 0 (apart from the live level bits), the mask reads 0xFFFFFFFF, the card I/O status reads 0, the card I/O mask reads 0x0000FFFF, the card I/O enable reads 0, and `irq_o` is 0.
- R2: A pulse on `evt_i[k]` sets status bit k at the next edge, and the bit stays set after the pulse. The bits are 0 cmd done, 1 cmd timeout, 2 data done, 3 CRC error, 4 data timeout, 5 rx ready, 6 tx request, 7 rx overflow, 8 tx underrun, 9 card inserted, 10 card removed.
- R3: A write to address 0 clears each event bit whose written bit is 0 and leaves each event bit whose written bit is 1 unchanged. The write has no effect on the level bits.
- R4: When an event pulse and a write of 0 to the same status bit happen in one cycle, the bit ends up set.
- R5: Status bit 16 shows `wp_i` and bit 17 shows `busy_i` as current levels, in the same cycle.
- R6: A mask bit of 1 blocks its source and a mask bit of 0 enables it. A masked event is still latched in the status.
- R7: `irq_o` rises one clock after an unmasked pending bit appears. It falls one clock after the last pending bit is cleared or masked.
- R8: The level bits never cause `irq_o`, even when fully unmasked.
- R9: While card I/O enable bit 0 is 0, a pulse on `sdio_evt_i` is ignored. Card I/O status bit 0 is then not set.
- R10: The card I/O pending term is status bit 0 AND NOT mask bit 0 AND enable bit 0. Clearing the enable drops `irq_o` but keeps the status bit.
- R11: A write to address 2 with bit 0 at 0 clears card I/O status bit 0.
- R12: Unmapped addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| evt_i | input | 11 | Event pulses, bit order as in R2 |
| wp_i | input | 1 | Write-protect level |
| busy_i | input | 1 | Command-busy level |
| sdio_evt_i | input | 1 | Card I/O interrupt pulse |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Register contents change at the edge that samples a write or an event. Reads are combinational, so the new value can be read back half a cycle later. `irq_o` adds one more register and is therefore due one full cycle after the state change. Each table step drives its inputs at a falling edge and reads the register back at the next falling edge. It checks `irq_o` one falling edge after that. The directed timing test also samples `irq_o` at the intermediate point, to show that it is still at its old value there. Live level bits are checked within the same cycle as the input change.

// File: rtl/sdmmc_irq_agg.sv
module sdmmc_irq_agg #(
  parameter int STAT_W   = 32,
  parameter int EVT_N    = 11,
  parameter int SDIO_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int WP_BIT   = 16,
  parameter int BUSY_BIT = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [STAT_W-1:0] bus_rdata,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic              sdio_evt_i,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SSTAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SMASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SCTRL = ADDR_W'(4);

  logic [EVT_N-1:0]  stat_q;
  logic [STAT_W-1:0] mask_q;
  logic              sdio_q;
  logic [SDIO_W-1:0] sdio_mask_q;
  logic              sdio_en_q;
  logic              irq_q;

  logic wr_stat, wr_mask, wr_sstat, wr_smask, wr_sctrl;
  assign wr_stat  = bus_we && (bus_addr == A_STAT);
  assign wr_mask  = bus_we && (bus_addr == A_MASK);
  assign wr_sstat = bus_we && (bus_addr == A_SSTAT);
  assign wr_smask = bus_we && (bus_addr == A_SMASK);
  assign wr_sctrl = bus_we && (bus_addr == A_SCTRL);

  logic [EVT_N-1:0] stat_d;
  logic             sdio_d;
  assign stat_d = (wr_stat ? (stat_q & bus_wdata[EVT_N-1:0]) : stat_q) | evt_i;
  assign sdio_d = (wr_sstat ? (sdio_q & bus_wdata[0]) : sdio_q) | (sdio_evt_i & sdio_en_q);

  logic sd_pend, sdio_pend;
  assign sd_pend   = |(stat_q & ~mask_q[EVT_N-1:0]);
  assign sdio_pend = sdio_q & ~sdio_mask_q[0] & sdio_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q      <= '0;
      mask_q      <= '1;
      sdio_q      <= 1'b0;
      sdio_mask_q <= '1;
      sdio_en_q   <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      stat_q <= stat_d;
      sdio_q <= sdio_d;
      if (wr_mask)  mask_q      <= bus_wdata;
      if (wr_smask) sdio_mask_q <= bus_wdata[SDIO_W-1:0];
      if (wr_sctrl) sdio_en_q   <= bus_wdata[0];
      irq_q <= sd_pend | sdio_pend;
    end
  end

  assign irq_o = irq_q;

  logic [STAT_W-1:0] stat_word;
  always_comb begin
    stat_word              = '0;
    stat_word[EVT_N-1:0]   = stat_q;
    stat_word[WP_BIT]      = wp_i;
    stat_word[BUSY_BIT]    = busy_i;
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = stat_word;
      A_MASK:  bus_rdata = mask_q;
      A_SSTAT: bus_rdata = STAT_W'(sdio_q);
      A_SMASK: bus_rdata = STAT_W'(sdio_mask_q);
      A_SCTRL: bus_rdata = STAT_W'(sdio_en_q);
      default: bus_rdata = '0;
    endcase
  end

endmodule

module sdmmc_irq_agg_chk #(
  parameter int STAT_W   = 32,
  parameter int EVT_N    = 11,
  parameter int ADDR_W   = 3,
  parameter int WP_BIT   = 16,
  parameter int BUSY_BIT = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [EVT_N-1:0]  wr_bits,
  input logic [STAT_W-1:0] bus_rdata,
  input logic [EVT_N-1:0]  evt_i,
  input logic              wp_i,
  input logic              busy_i,
  input logic              irq_o,
  input logic [EVT_N-1:0]  stat_q,
  input logic [EVT_N-1:0]  mask_lo,
  input logic              sdio_q,
  input logic              sdio_mask0,
  input logic              sdio_en_q
);

  logic wr_stat, wr_sstat, any_pend;
  assign wr_stat  = bus_we && (bus_addr == ADDR_W'(0));
  assign wr_sstat = bus_we && (bus_addr == ADDR_W'(2));
  assign any_pend = (|(stat_q & ~mask_lo)) || (sdio_q && !sdio_mask0 && sdio_en_q);

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && evt_i == '0) |=> ((stat_q & ~$past(wr_bits)) == '0)); // R3

  AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && evt_i == '0) |=> ((stat_q & $past(wr_bits)) == ($past(stat_q) & $past(wr_bits)))); // R3

  AST_LEVEL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata[WP_BIT] == wp_i && bus_rdata[BUSY_BIT] == busy_i)); // R5

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> irq_o); // R7

  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !irq_o); // R7

  AST_SDIO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdio_en_q && !wr_sstat) |=> (sdio_q == $past(sdio_q))); // R9

endmodule

bind sdmmc_irq_agg sdmmc_irq_agg_chk #(
  .STAT_W(STAT_W), .EVT_N(EVT_N), .ADDR_W(ADDR_W), .WP_BIT(WP_BIT), .BUSY_BIT(BUSY_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wr_bits(bus_wdata[EVT_N-1:0]), .bus_rdata(bus_rdata), .evt_i(evt_i),
  .wp_i(wp_i), .busy_i(busy_i), .irq_o(irq_o), .stat_q(stat_q),
  .mask_lo(mask_q[EVT_N-1:0]), .sdio_q(sdio_q), .sdio_mask0(sdio_mask_q[0]),
  .sdio_en_q(sdio_en_q)
);

// File: tb/tb_sdmmc_irq_agg.sv
module tb_sdmmc_irq_agg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] evt_i = '0;
  logic        wp_i = 1'b0;
  logic        busy_i = 1'b0;
  logic        sdio_evt_i = 1'b0;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdmmc_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .wp_i(wp_i), .busy_i(busy_i), .sdio_evt_i(sdio_evt_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [10:0] evt;
    logic        sevt;
    logic [2:0]  raddr;
    logic [31:0] exp;
    logic        eirq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'h0,        11'h001, 1'b0, 3'd0, 32'h00000001, 1'b0}, // R2 R6
    '{1'b1, 3'd1, 32'hFFFFFFFE, 11'h000, 1'b0, 3'd1, 32'hFFFFFFFE, 1'b1}, // R6 R7
    '{1'b1, 3'd0, 32'hFFFFFFFE, 11'h000, 1'b0, 3'd0, 32'h00000000, 1'b0}, // R3 R7
    '{1'b0, 3'd0, 32'h0,        11'h204, 1'b0, 3'd0, 32'h00000204, 1'b0}, // R2 R6
    '{1'b1, 3'd0, 32'hFFFFFFFB, 11'h004, 1'b0, 3'd0, 32'h00000204, 1'b0}, // R4
    '{1'b1, 3'd0, 32'hFFFFFDFF, 11'h000, 1'b0, 3'd0, 32'h00000004, 1'b0}, // R3
    '{1'b1, 3'd1, 32'hFFFFFFFB, 11'h000, 1'b0, 3'd1, 32'hFFFFFFFB, 1'b1}, // R6
    '{1'b1, 3'd1, 32'hFFFFFFFF, 11'h000, 1'b0, 3'd0, 32'h00000004, 1'b0}, // R7
    '{1'b0, 3'd0, 32'h0,        11'h7F8, 1'b0, 3'd0, 32'h000007FC, 1'b0}, // R2
    '{1'b1, 3'd0, 32'h00000000, 11'h000, 1'b0, 3'd0, 32'h00000000, 1'b0}, // R3
    '{1'b1, 3'd0, 32'hFFFFFFFF, 11'h7FF, 1'b0, 3'd0, 32'h000007FF, 1'b0}, // R2 R3
    '{1'b1, 3'd0, 32'h00000000, 11'h000, 1'b0, 3'd0, 32'h00000000, 1'b0}, // R3
    '{1'b1, 3'd4, 32'h00000001, 11'h000, 1'b0, 3'd4, 32'h00000001, 1'b0}, // R10
    '{1'b0, 3'd0, 32'h0,        11'h000, 1'b1, 3'd2, 32'h00000001, 1'b0}, // R9 R6
    '{1'b1, 3'd3, 32'h0000FFFE, 11'h000, 1'b0, 3'd3, 32'h0000FFFE, 1'b1}, // R10
    '{1'b1, 3'd4, 32'h00000000, 11'h000, 1'b0, 3'd2, 32'h00000001, 1'b0}, // R10
    '{1'b1, 3'd4, 32'h00000001, 11'h000, 1'b0, 3'd4, 32'h00000001, 1'b1}, // R10
    '{1'b1, 3'd2, 32'h0000FFFE, 11'h000, 1'b0, 3'd2, 32'h00000000, 1'b0}, // R11
    '{1'b1, 3'd4, 32'h00000000, 11'h000, 1'b0, 3'd4, 32'h00000000, 1'b0}, // R10
    '{1'b0, 3'd0, 32'h0,        11'h000, 1'b1, 3'd2, 32'h00000000, 1'b0}, // R9
    '{1'b0, 3'd0, 32'h0,        11'h000, 1'b0, 3'd7, 32'h00000000, 1'b0}  // R12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_check("R1", 3'd0, 32'h0);
    rd_check("R1", 3'd1, 32'hFFFFFFFF);
    rd_check("R1", 3'd2, 32'h0);
    rd_check("R1", 3'd3, 32'h0000FFFF);
    rd_check("R1", 3'd4, 32'h0);
    check("R1", {31'd0, irq_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_we = VECS[i].we; bus_addr = VECS[i].addr; bus_wdata = VECS[i].wdata;
      evt_i = VECS[i].evt; sdio_evt_i = VECS[i].sevt;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0; evt_i = '0; sdio_evt_i = 1'b0;
      rd_check($sformatf("table step %0d read", i), VECS[i].raddr, VECS[i].exp);
      @(negedge clk);
      #1;
      check($sformatf("table step %0d irq", i), {31'd0, irq_o}, {31'd0, VECS[i].eirq});
    end

    // R7 timing: one cycle of latency on rise and fall
    wr(3'd1, 32'hFFFFFFFE);
    evt_i = 11'h001;
    @(negedge clk);
    evt_i = '0;
    #1;
    check("R7 rise not yet", {31'd0, irq_o}, 32'd0);
    @(negedge clk); #1;
    check("R7 rise", {31'd0, irq_o}, 32'd1);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'hFFFFFFFE;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    #1;
    check("R7 fall not yet", {31'd0, irq_o}, 32'd1);
    @(negedge clk); #1;
    check("R7 fall", {31'd0, irq_o}, 32'd0);

    // R5 R8 level bits
    wp_i = 1'b1; busy_i = 1'b1;
    rd_check("R5 live levels", 3'd0, 32'h00030000);
    wr(3'd1, 32'h00000000);
    @(negedge clk); #1;
    check("R8 levels no irq", {31'd0, irq_o}, 32'd0);
    wr(3'd0, 32'h00000000);
    rd_check("R3 levels unaffected", 3'd0, 32'h00030000);
    wp_i = 1'b0;
    rd_check("R5 wp follows", 3'd0, 32'h00020000);
    busy_i = 1'b0;
    wr(3'd1, 32'hFFFFFFFF);
    rd_check("R12 unmapped 5", 3'd5, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule